// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Generator

This block is a clocked pulse stretcher with several identical, independent channels. Each channel has three control inputs: a falling-edge trigger input, a rising-edge trigger input and an active-low clear. It drives a pulse output and that output's complement. A valid trigger starts a pulse whose length, in clock cycles, comes from a per-channel width input. A further valid trigger during the pulse restarts the full length. Triggers that arrive faster than the width therefore hold the output high without a gap.

A trigger is qualified by the levels of the other two inputs. A falling edge on the falling-edge input fires only while the rising-edge input and clear are both high. A rising edge on the rising-edge input fires only while the falling-edge input is low and clear is high. Clear also feeds the trigger gate, so a rising edge on clear fires the channel when the falling-edge input is low and the rising-edge input is high. While clear is low, the pulse is forced off and no trigger is accepted.

All inputs pass through a two-flop synchronizer before edge detection. An edge is found by comparing each synchronized input with its value on the cycle before.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `trig_fall_i` fires the channel when `trig_rise_i` and `clr_n_i` are both high. A rising edge on `trig_fall_i` never fires it.
- R2: A rising edge on `trig_rise_i` fires the channel when `trig_fall_i` is low and `clr_n_i` is high. A falling edge on `trig_rise_i` never fires it.
- R3: A rising edge on `clr_n_i` fires the channel when `trig_fall_i` is low and `trig_rise_i` is high. With `trig_rise_i` low it does not fire.
- R4: While `trig_fall_i` is high or `trig_rise_i` is low, no edge on the other inputs fires the channel, except a falling edge on `trig_fall_i` itself.
- R5: When `clr_n_i` goes low, `q_o` is low from the third rising clock edge after the change. While `clr_n_i` stays low, no edge fires the channel.
- R6: After a valid trigger edge is applied, `q_o` goes high at the third rising clock edge and stays high for exactly `width` clock cycles.
- R7: A valid trigger during a pulse restarts the count, so the pulse ends `width` cycles after the last trigger.
- R8: Valid triggers spaced closer than `width` cycles keep `q_o` high continuously.
- R9: A width of zero produces no pulse.
- R10: `q_n_o` is always the inverse of `q_o`.
- R11: The channels are independent. Activity on one channel leaves the outputs of another unchanged.
- R12: A synchronous reset (`rst` high) forces `q_o` low. Input levels held through reset do not fire a trigger when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_fall_i | input | NCH | Per-channel falling-edge trigger input |
| trig_rise_i | input | NCH | Per-channel rising-edge trigger input |
| clr_n_i | input | NCH | Per-channel clear, active low; its rising edge can also trigger |
| width_i | input | NCH*CNT_W | Per-channel pulse length in clock cycles, channel 0 in the low bits |
| q_o | output | NCH | Pulse outputs |
| q_n_o | output | NCH | Complement of the pulse outputs |

## Verification
The hardest cases to reach from the ports are the ones where a trigger edge must not fire because of the level already on another input. Every such test therefore has to start from known input levels that did not themselves cause a pulse. Before each vector, the bench pulls clear low, moves the two trigger inputs to their starting levels, restores clear, and waits out any pulse this caused. Only then does it apply the single input change under test. Retriggering and continuous high output are reached with directed sequences that re-edge the rising-edge input inside a running pulse. In the retrigger case, the sample points are chosen so that a pulse without a restart would already have ended.

// File: rtl/osh_pkg.sv
package osh_pkg;
  // Synchronized levels of one channel's three control inputs.
  typedef struct packed {
    logic fall_in;   // falling-edge trigger input
    logic rise_in;   // rising-edge trigger input
    logic clr_n;     // active-low clear
  } osh_lvl_t;

  // Trigger decision from the previous and current synchronized levels.
  function automatic logic osh_fire(osh_lvl_t prev, osh_lvl_t cur);
    logic f_edge, r_edge, c_edge;
    f_edge = prev.fall_in & ~cur.fall_in;
    r_edge = ~prev.rise_in & cur.rise_in;
    c_edge = ~prev.clr_n & cur.clr_n;
    return (f_edge & cur.rise_in & cur.clr_n)
         | (r_edge & ~cur.fall_in & cur.clr_n)
         | (c_edge & ~cur.fall_in & cur.rise_in);
  endfunction

  // Next value of the remaining-cycle counter.
  function automatic logic [31:0] osh_next(logic clr, logic fire,
                                           logic [31:0] width, logic [31:0] rem);
    if (clr)           return '0;
    else if (fire)     return width;
    else if (rem != 0) return rem - 32'd1;
    else               return '0;
  endfunction
endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  // During reset both stages take the live level, so release causes no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= d;
      q      <= d;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/osh_gate.sv
module osh_gate
  import osh_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  osh_lvl_t lvl,
  output logic     fire,
  output logic     clr_act
);
  osh_lvl_t hist;

  always_ff @(posedge clk) begin
    hist <= lvl;
  end

  assign fire    = rst ? 1'b0 : osh_fire(hist, lvl);
  assign clr_act = ~lvl.clr_n;
endmodule

// File: rtl/osh_timer.sv
module osh_timer
  import osh_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             clr_act,
  input  logic [CNT_W-1:0] width,
  output logic             q
);
  logic [CNT_W-1:0] rem;
  logic [31:0]      nxt;

  assign nxt = osh_next(clr_act, fire, 32'(width), 32'(rem));

  always_ff @(posedge clk) begin
    if (rst) rem <= '0;
    else     rem <= nxt[CNT_W-1:0];
  end

  assign q = (rem != '0);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import osh_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       trig_fall_i,
  input  logic [NCH-1:0]       trig_rise_i,
  input  logic [NCH-1:0]       clr_n_i,
  input  logic [NCH*CNT_W-1:0] width_i,
  output logic [NCH-1:0]       q_o,
  output logic [NCH-1:0]       q_n_o
);
  localparam int LVL_W = $bits(osh_lvl_t);

  // Internal events brought out for the checker.
  logic [NCH-1:0] fire_w;
  logic [NCH-1:0] clr_w;
  logic [NCH-1:0] q_w;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [LVL_W-1:0] raw;
    logic [LVL_W-1:0] syn;
    osh_lvl_t         lvl;

    assign raw = {trig_fall_i[ch], trig_rise_i[ch], clr_n_i[ch]};
    assign lvl = osh_lvl_t'(syn);

    osh_sync #(.W(LVL_W)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (syn)
    );

    osh_gate u_gate (
      .clk     (clk),
      .rst     (rst),
      .lvl     (lvl),
      .fire    (fire_w[ch]),
      .clr_act (clr_w[ch])
    );

    osh_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .fire    (fire_w[ch]),
      .clr_act (clr_w[ch]),
      .width   (width_i[ch*CNT_W +: CNT_W]),
      .q       (q_w[ch])
    );
  end

  assign q_o   = q_w;
  assign q_n_o = ~q_w;
endmodule

// File: rtl/osh_chk.sv
module osh_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NCH-1:0]       fire,
  input logic [NCH-1:0]       clr,
  input logic [NCH*CNT_W-1:0] width,
  input logic [NCH-1:0]       q
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_fire_starts_r6: assert property (@(posedge clk) disable iff (rst)
      (fire[i] && width[i*CNT_W +: CNT_W] != '0) |=> q[i]);

    p_zero_width_r9: assert property (@(posedge clk) disable iff (rst)
      (fire[i] && width[i*CNT_W +: CNT_W] == '0 && !q[i]) |=> !q[i]);

    p_clear_drops_r5: assert property (@(posedge clk) disable iff (rst)
      clr[i] |=> !q[i]);

    p_rise_needs_fire_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(q[i]) |-> $past(fire[i]));

    p_retrig_holds_r7: assert property (@(posedge clk) disable iff (rst)
      (q[i] && fire[i] && width[i*CNT_W +: CNT_W] != '0) |=> q[i]);
  end
endmodule

bind retrig_oneshot osh_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .fire  (fire_w),
  .clr   (clr_w),
  .width (width_i),
  .q     (q_w)
);

// File: tb/retrig_oneshot_tb.sv
module retrig_oneshot_tb;
  localparam int PERIOD = 10;
  localparam int NCH    = 2;
  localparam int CNT_W  = 16;
  localparam int NV     = 14;

  // Vector fields: [14] channel, [13:11] start levels {fall,rise,clr_n},
  // [10:8] applied levels, [7:1] width, [0] pulse expected.
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 3'b111, 3'b011, 7'd5, 1'b1},
    {1'b0, 3'b101, 3'b001, 7'd5, 1'b0},
    {1'b0, 3'b001, 3'b011, 7'd6, 1'b1},
    {1'b0, 3'b101, 3'b111, 7'd5, 1'b0},
    {1'b0, 3'b000, 3'b010, 7'd5, 1'b0},
    {1'b0, 3'b010, 3'b011, 7'd7, 1'b1},
    {1'b0, 3'b110, 3'b111, 7'd5, 1'b0},
    {1'b0, 3'b000, 3'b001, 7'd5, 1'b0},
    {1'b0, 3'b111, 3'b011, 7'd0, 1'b0},
    {1'b0, 3'b111, 3'b011, 7'd1, 1'b1},
    {1'b0, 3'b011, 3'b111, 7'd5, 1'b0},
    {1'b1, 3'b111, 3'b011, 7'd9, 1'b1},
    {1'b1, 3'b001, 3'b011, 7'd4, 1'b1},
    {1'b0, 3'b011, 3'b001, 7'd5, 1'b0}
  };

  logic                 clk = 1'b0;
  logic                 rst;
  logic [NCH-1:0]       fa, rb, cn;
  logic [NCH*CNT_W-1:0] wid;
  logic [NCH-1:0]       q, qn;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  retrig_oneshot #(.NCH(NCH), .CNT_W(CNT_W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .trig_fall_i (fa),
    .trig_rise_i (rb),
    .clr_n_i     (cn),
    .width_i     (wid),
    .q_o         (q),
    .q_n_o       (qn)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";  1: return "R4";  2: return "R2";  3: return "R4";
      4: return "R5";  5: return "R3";  6: return "R4";  7: return "R3";
      8: return "R9";  9: return "R6";  10: return "R1"; 11: return "R11";
      12: return "R2"; default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic put(input int ch, input logic [2:0] lv);
    fa[ch] = lv[2];
    rb[ch] = lv[1];
    cn[ch] = lv[0];
  endtask

  // Reach start levels without leaving a pulse running.
  task automatic prep(input int ch, input logic [2:0] lv, input int w);
    cn[ch] = 1'b0;
    repeat (4) @(negedge clk);
    fa[ch] = lv[2];
    rb[ch] = lv[1];
    repeat (4) @(negedge clk);
    cn[ch] = lv[0];
    repeat (w + 8) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit [31:0] hist;
    int cnt;
    int qn_bad;
    rst = 1'b1;
    wid = '0;
    fa = '0;
    rb = '1;
    cn = '1;   // trigger-ready levels held through reset
    repeat (4) @(negedge clk);
    check(q == '0, "R12 reset q", int'(q), 0);
    check(qn == '1, "R12 reset q_n", int'(qn), 3);
    wid = {16'd5, 16'd5};
    rst = 1'b0;
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (q != '0) cnt++;
    end
    check(cnt == 0, "R12 no pulse after release", cnt, 0);

    // Vector table.
    put(0, 3'b101);
    put(1, 3'b101);
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      int ch, oc, w, first, hi, ohi;
      v = VEC[i];
      ch = int'(v[14]);
      oc = 1 - ch;
      w = int'(v[7:1]);
      wid[ch*CNT_W +: CNT_W] = CNT_W'(w);
      prep(ch, v[13:11], w);
      put(ch, v[10:8]);
      first = -1;
      hi = 0;
      ohi = 0;
      qn_bad = 0;
      for (int k = 1; k <= w + 8; k++) begin
        @(negedge clk);
        if (q[ch]) begin
          hi++;
          if (first < 0) first = k;
        end
        if (q[oc]) ohi++;
        if (qn != ~q) qn_bad++;
      end
      if (v[0]) begin
        check(hi == w, {tag_of(i), " pulse length"}, hi, w);
        check(first == 3, "R6 rise latency", first, 3);
      end else begin
        check(hi == 0, {tag_of(i), " no pulse"}, hi, 0);
      end
      check(ohi == 0, "R11 other channel quiet", ohi, 0);
      check(qn_bad == 0, "R10 complement", qn_bad, 0);
    end

    // R7: retrigger inside the pulse restarts the full width.
    wid[0 +: CNT_W] = 16'd6;
    prep(0, 3'b001, 6);
    rb[0] = 1'b1;
    hist = '0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      hist[k] = q[0];
      if (k == 2) rb[0] = 1'b0;
      if (k == 4) rb[0] = 1'b1;
    end
    check(hist[12] == 1'b1, "R7 still high after first width", int'(hist[12]), 1);
    check(hist[13] == 1'b0, "R7 ends width after retrigger", int'(hist[13]), 0);
    check($countones(hist[12:3]) == 10, "R7 continuous", $countones(hist[12:3]), 10);

    // R8: triggers every 4 cycles with width 5 hold q high.
    wid[0 +: CNT_W] = 16'd5;
    prep(0, 3'b001, 5);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k >= 3 && q[0]) cnt++;
      if (k % 4 == 0) rb[0] = 1'b1;
      if (k % 4 == 2) rb[0] = 1'b0;
    end
    check(cnt == 37, "R8 full duty", cnt, 37);

    // R5: clear ends the pulse and blocks a trigger while low.
    wid[0 +: CNT_W] = 16'd20;
    prep(0, 3'b001, 20);
    rb[0] = 1'b1;
    hist = '0;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      hist[k] = q[0];
      if (k == 5) cn[0] = 1'b0;
      if (k == 9) rb[0] = 1'b0;
      if (k == 11) rb[0] = 1'b1;
    end
    check(hist[7] == 1'b1, "R5 high before clear takes effect", int'(hist[7]), 1);
    check(hist[15:8] == '0, "R5 low while cleared", int'(hist[15:8]), 0);

    summary();
    $finish;
  end
endmodule